// File: doc/BRIEF.md
# Peripheral interrupt flag register

This block holds eight event flags raised by peripheral sources, together with an eight-bit enable register. Each source owns exactly one flag bit and raises it with a one-cycle pulse on its `hw_set` line. Flags that mirror the state of a serial port buffer (transmit ready, receive full) also have a `hw_clr` line, because hardware must be able to drop them again. Software writes to these status flags have no effect.

Software reads both registers and writes them through a simple register strobe interface. A write to the flag register changes only the bits in a parameterised writable mask. A second parameter, the valid mask, marks which bits exist at all. Bits outside the valid mask read as zero and can never request an interrupt.

The block drives a registered, level-sensitive request to the global interrupt controller. The request is high whenever a valid flag and its enable are both set.

Top module: `perif_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, the flags, the enables and `irq_req` all become zero.
- R2: A write to the flag register (`wr_flags`) gives the result (`wdata` AND writable mask) OR (old flags AND NOT writable mask). Bits outside the writable mask keep their value.
- R3: With the default masks (valid 8'hFF, writable 8'hCF), bit 4 (transmit ready) and bit 5 (receive full) are valid but not writable by software. They change only through `hw_set` and `hw_clr`.
- R4: A `hw_set` pulse ORs its bits into the flags. A `hw_clr` pulse removes only its own bits. Both take effect at the next clock edge.
- R5: When `hw_set` for a bit arrives in the same cycle as a software write or a `hw_clr` to that bit, the flag ends up set.
- R6: After each clock edge, `irq_req` is high exactly when (flags AND enables AND valid mask) is non-zero. It stays high over idle cycles until the flag is cleared or the enable is removed.
- R7: Bits outside the valid mask read as zero in both registers. They are not changed by writes or by `hw_set`, and they never assert `irq_req`.
- R8: A write to the enable register (`wr_enables`) stores `wdata` AND the valid mask. The stored value reads back on `enables_rd`.
- R9: Clearing the only pending enabled flag with `hw_clr` drops `irq_req` at the next edge. A clear never raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_flags | input | 1 | Software write strobe for the flag register |
| wr_enables | input | 1 | Software write strobe for the enable register |
| wdata | input | 8 | Software write data |
| hw_set | input | 8 | Per-bit set pulses from peripheral sources |
| hw_clr | input | 8 | Per-bit clear pulses for status-style flags |
| flags_rd | output | 8 | Flag register read value |
| enables_rd | output | 8 | Enable register read value |
| irq_req | output | 1 | Registered peripheral interrupt request |

## Verification
The hardest case to reach from the ports is a collision: a software write, a hardware set and a hardware clear all land on the same bit in one cycle. Only a directed scenario produces it. The bench first preloads a known flag pattern, then drives all three strobes together on chosen bits. It checks that the set always survives, while untouched read-only bits hold their value. The effect of the unimplemented bits is only visible with a sparse valid mask, so a second instance with such masks is driven from the same stimulus.

// File: rtl/perif_irq_flags.sv
module perif_irq_flags #(
  parameter int          W       = 8,
  parameter logic [W-1:0] VALID_M = 8'hFF,
  parameter logic [W-1:0] WR_M    = 8'hCF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_flags,
  input  logic         wr_enables,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] flags_rd,
  output logic [W-1:0] enables_rd,
  output logic         irq_req
);
  localparam logic [W-1:0] WRV = WR_M & VALID_M;

  logic [W-1:0] flag_q, en_q, flag_d, en_d, sw_val;
  logic         irq_q;

  // software merge first, then hardware clear, then hardware set (set wins)
  assign sw_val = wr_flags ? ((wdata & WRV) | (flag_q & ~WRV)) : flag_q;
  assign flag_d = ((sw_val & ~hw_clr) | hw_set) & VALID_M;
  assign en_d   = wr_enables ? (wdata & VALID_M) : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= |(flag_d & en_d);
    end
  end

  assign flags_rd   = flag_q;
  assign enables_rd = en_q;
  assign irq_req    = irq_q;

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req == (|(flags_rd & enables_rd & VALID_M)));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|(hw_set & VALID_M)) |=> ((flags_rd & $past(hw_set & VALID_M)) == $past(hw_set & VALID_M)));

  assert_clr_only_R4: assert property (@(posedge clk) disable iff (rst)
    (|(hw_clr & ~hw_set)) |=> ((flags_rd & $past(hw_clr & ~hw_set)) == '0));

  assert_ro_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (((hw_set | hw_clr) & ~WRV) == '0) |=> ((flags_rd & ~WRV) == $past(flags_rd & ~WRV)));

  assert_unimpl_R7: assert property (@(posedge clk) disable iff (rst)
    (((flags_rd | enables_rd) & ~VALID_M) == '0));
endmodule

// File: tb/perif_irq_flags_tb_top.sv
module perif_irq_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_flags = 1'b0, wr_enables = 1'b0;
  logic [7:0] wdata = '0, hw_set = '0, hw_clr = '0;
  logic [7:0] fa, ea, fb, eb;
  logic       ia, ib;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  perif_irq_flags dut_i (
    .clk(clk), .rst(rst), .wr_flags(wr_flags), .wr_enables(wr_enables),
    .wdata(wdata), .hw_set(hw_set), .hw_clr(hw_clr),
    .flags_rd(fa), .enables_rd(ea), .irq_req(ia));

  perif_irq_flags #(.VALID_M(8'h3B), .WR_M(8'h0B)) dut_b_i (
    .clk(clk), .rst(rst), .wr_flags(wr_flags), .wr_enables(wr_enables),
    .wdata(wdata), .hw_set(hw_set), .hw_clr(hw_clr),
    .flags_rd(fb), .enables_rd(eb), .irq_req(ib));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wf, input logic we, input logic [7:0] d,
                     input logic [7:0] s, input logic [7:0] c);
    wr_flags = wf; wr_enables = we; wdata = d; hw_set = s; hw_clr = c;
    @(negedge clk);
    wr_flags = 0; wr_enables = 0; wdata = '0; hw_set = '0; hw_clr = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 flags", fa, 8'h00);
    chk("R1 enables", ea, 8'h00);
    chk("R1 irq", {7'd0, ia}, 8'h00);
  endtask

  task automatic t_sw_write;
    cyc(1, 0, 8'hFF, 0, 0);
    chk("R2 masked write", fa, 8'hCF);
    chk("R6 no enable no irq", {7'd0, ia}, 8'h00);
    cyc(1, 0, 8'h41, 0, 0);
    chk("R2 partial write", fa, 8'h41);
    cyc(1, 0, 8'h00, 0, 0);
    chk("R2 clear write", fa, 8'h00);
  endtask

  task automatic t_enable_irq;
    cyc(0, 1, 8'h01, 0, 0);
    chk("R8 enable readback", ea, 8'h01);
    chk("R6 enable alone", {7'd0, ia}, 8'h00);
    cyc(1, 0, 8'h01, 0, 0);
    chk("R6 irq on write", {7'd0, ia}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R6 irq held", {7'd0, ia}, 8'h01);
    cyc(0, 1, 8'h00, 0, 0);
    chk("R6 irq drop on disable", {7'd0, ia}, 8'h00);
    cyc(0, 1, 8'h01, 0, 0);
    chk("R6 irq back on enable", {7'd0, ia}, 8'h01);
    cyc(1, 0, 8'h00, 0, 0);
    chk("R6 irq drop on sw clear", {7'd0, ia}, 8'h00);
  endtask

  task automatic t_status_bits;
    cyc(0, 0, 0, 8'h10, 0);
    chk("R4 hw set", fa, 8'h10);
    cyc(1, 0, 8'h00, 0, 0);
    chk("R3 sw cannot clear tx", fa, 8'h10);
    cyc(1, 0, 8'h20, 0, 0);
    chk("R3 sw cannot set rx", fa, 8'h10);
    cyc(0, 0, 0, 0, 8'h10);
    chk("R4 hw clear", fa, 8'h00);
    cyc(0, 1, 8'h20, 0, 0);
    cyc(0, 0, 0, 8'h20, 0);
    chk("R6 irq from hw set", {7'd0, ia}, 8'h01);
    cyc(0, 0, 0, 8'h01, 0);
    cyc(0, 0, 0, 0, 8'h20);
    chk("R4 clear only own bit", fa, 8'h01);
    chk("R9 irq drop on hw clear", {7'd0, ia}, 8'h00);
    cyc(0, 0, 0, 0, 8'h01);
    chk("R9 clear no irq", {7'd0, ia}, 8'h00);
  endtask

  task automatic t_collision;
    cyc(1, 0, 8'h02, 0, 0);
    cyc(0, 0, 0, 8'h10, 0);
    chk("R5 preload", fa, 8'h12);
    cyc(1, 0, 8'h00, 8'h03, 8'h00);
    chk("R5 set beats sw write", fa, 8'h13);
    cyc(0, 0, 0, 8'h40, 8'h40);
    chk("R5 set beats hw clear", fa, 8'h53);
    cyc(1, 0, 8'h00, 8'h20, 8'h10);
    chk("R5 triple collision", fa, 8'h20);
  endtask

  task automatic t_unimpl;
    t_reset();
    cyc(1, 0, 8'hFF, 0, 0);
    chk("R7 sparse write", fb, 8'h0B);
    cyc(0, 0, 0, 8'hFF, 0);
    chk("R7 sparse hw set", fb, 8'h3B);
    cyc(0, 1, 8'h84, 0, 0);
    chk("R7 enable unimpl reads zero", eb, 8'h00);
    chk("R7 no irq from unimpl", {7'd0, ib}, 8'h00);
    cyc(0, 1, 8'hFF, 0, 0);
    chk("R7 enable valid only", eb, 8'h3B);
    chk("R6 sparse irq", {7'd0, ib}, 8'h01);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sw_write();
    t_enable_irq();
    t_status_bits();
    t_collision();
    t_unimpl();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule